// File: doc/BRIEF.md
# Programmed-I/O Transfer FIFO with Command Capture

This block is the byte queue that sits behind the FIFO register of a disk-bus host adapter when bytes move by programmed I/O. The host pushes bytes with a write strobe and pops them with a read strobe. The block tracks a signed count of bytes still queued, a read pointer and a write pointer, and pulses an interrupt request for every byte it hands back. It can also preload a two-byte status/message reply in one cycle.

A command-capture input sends host writes into a separate command buffer instead of the queue. A select-and-stop sequence uses this mode to collect command bytes, and a neighbouring sequencer reads them back by index. A transfer-phase input tells the block when the bus is in the data-out phase. In that phase a read yields a zero byte instead of queue contents. Overrun is flagged one entry before the storage is physically full. Both pointers return to zero whenever a read drains the queue.

Top module: `pio_xfer_fifo`

## Requirements
- R1: After reset the count, both pointers, the read data, the interrupt pulse, the overrun flag, the flags value and the command length are all zero.
- R2: With capture mode off, a write strobe stores the byte and raises the count by one. Reads in a phase other than data-out return the bytes in the order they were written.
- R3: A write that arrives while the count is 15 (DEPTH-1) is discarded. The count stays at 15 and the sticky overrun output goes to 1.
- R4: With capture mode on, a write places its byte in the command buffer at index cmd_len and increments cmd_len, and the FIFO count does not change. Once cmd_len reaches 16, further captured bytes are dropped and cmd_len stays at 16.
- R5: A read strobe with a positive count lowers the count by one. On the following clock the block presents the next byte on rd_data and pulses irq high for one cycle.
- R6: In the data-out phase (phase bits [2:1] equal to 2'b00), a read with a positive count returns 8'h00, lowers the count and pulses irq, but does not advance the read pointer.
- R7: A read that takes the count from 1 to 0 resets both the read pointer and the write pointer to 0.
- R8: A read strobe while the count is 0 leaves rd_data, the count and irq unchanged.
- R9: A load_status strobe sets the count to 2, resets both pointers and queues the status byte followed by 8'h00. It also sets the flags output to 8'd2.
- R10: When strobes coincide in one cycle, load_status takes precedence over read, and read takes precedence over write. The losing strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host byte read strobe |
| capture | input | 1 | Command-capture mode |
| phase | input | 3 | Current bus phase; bits [2:1]=00 marks data-out |
| load_status | input | 1 | Load the two-byte status reply |
| status_byte | input | 8 | Status byte for the reply |
| cmd_rd_addr | input | 4 | Command buffer read index |
| rd_data | output | 8 | Latched byte from the last effective read |
| irq | output | 1 | One-cycle interrupt request per byte read |
| count | output | 6 | Signed count of queued bytes |
| overrun | output | 1 | Sticky overrun flag |
| flags | output | 8 | Flags value (2 after a status load) |
| cmd_len | output | 5 | Number of captured command bytes |
| cmd_rd_data | output | 8 | Command byte at cmd_rd_addr |

## Verification
The pointer reset to zero on drain is the hardest behaviour to see at the ports, because a circular queue with wrapping pointers returns the same data whether or not the reset happens. The stimulus opens a gap between the pointers first. It writes two bytes, reads one in the data-out phase so the read pointer stays put, then drains the queue in the data-in phase. After that it writes and reads one new byte. That byte comes back only if both pointers went to index 0. Without the reset, the stale second byte would come back instead.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } fifo_op_e;

  // Strobe arbitration: status load beats read, read beats write.
  function automatic fifo_op_e pick_op(input logic ld, input logic rd, input logic wr);
    if (ld)      return OP_LOAD;
    else if (rd) return OP_READ;
    else if (wr) return OP_WRITE;
    else         return OP_IDLE;
  endfunction

  // Data-out phase: phase bits [2:1] both clear.
  function automatic logic phase_is_data_out(input logic [2:0] ph);
    return (ph[2:1] == 2'b00);
  endfunction

endpackage

// File: rtl/pio_byte_store.sv
module pio_byte_store #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             ld,
  input  logic [7:0]       ld_byte,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld) begin
      mem[0] <= ld_byte;
      mem[1] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture #(
  parameter int CMD_DEPTH = 16,
  parameter int AW = $clog2(CMD_DEPTH),
  parameter int LW = $clog2(CMD_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_we,
  input  logic [7:0]    cap_data,
  input  logic [AW-1:0] rd_addr,
  output logic [LW-1:0] len,
  output logic [7:0]    rd_data
);
  localparam logic [LW-1:0] LEN_MAX = LW'(CMD_DEPTH);

  logic [7:0] cbuf [CMD_DEPTH];
  logic       cap_room;

  assign cap_room = (len < LEN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
    end else if (cap_we && cap_room) begin
      len <= len + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_we && cap_room) cbuf[len[AW-1:0]] <= cap_data;
  end

  assign rd_data = cbuf[rd_addr];

  // R4
  cmd_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_MAX);
  // R4
  cmd_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && len == LEN_MAX) |=> $stable(len));
endmodule

// File: rtl/pio_xfer_ctrl.sv
module pio_xfer_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic                    load,
  input  logic                    capture,
  input  logic [2:0]              phase,
  input  logic [7:0]              store_rdata,
  output logic                    store_we,
  output logic                    cap_we,
  output logic [PTR_W-1:0]        rptr,
  output logic [PTR_W-1:0]        wptr,
  output logic signed [CNT_W-1:0] count,
  output logic [7:0]              rd_data,
  output logic                    irq,
  output logic                    overrun,
  output logic [7:0]              flags
);
  localparam logic signed [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH - 1);
  localparam logic signed [CNT_W-1:0] STAT_LVL = CNT_W'(2);

  fifo_op_e op;
  logic     fifo_wr, wr_ok, wr_ovr, rd_take, rd_drain, data_out;

  assign op       = pick_op(load, rd_en, wr_en);
  assign data_out = phase_is_data_out(phase);
  assign fifo_wr  = (op == OP_WRITE) && !capture;
  assign cap_we   = (op == OP_WRITE) && capture;
  assign wr_ok    = fifo_wr && (count != FULL_LVL);
  assign wr_ovr   = fifo_wr && (count == FULL_LVL);
  assign rd_take  = (op == OP_READ) && (count > 0);
  assign rd_drain = rd_take && (count == 1);
  assign store_we = wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rptr    <= '0;
      wptr    <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
      overrun <= 1'b0;
      flags   <= '0;
    end else begin
      irq <= 1'b0;
      if (op == OP_LOAD) begin
        count <= STAT_LVL;
        rptr  <= '0;
        wptr  <= '0;
        flags <= 8'd2;
      end else if (rd_take) begin
        count   <= count - 1'b1;
        irq     <= 1'b1;
        rd_data <= data_out ? 8'h00 : store_rdata;
        if (rd_drain) begin
          rptr <= '0;
          wptr <= '0;
        end else if (!data_out) begin
          rptr <= rptr + 1'b1;
        end
      end else if (wr_ok) begin
        count <= count + 1'b1;
        wptr  <= wptr + 1'b1;
      end else if (wr_ovr) begin
        overrun <= 1'b1;
      end
    end
  end

  // R3
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovr |=> (count == FULL_LVL) && overrun);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= 0) && (count <= FULL_LVL));
  // R4
  cap_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> $stable(count));
  // R5
  rd_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> (count == $past(count) - 1) && irq);
  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> !irq);
  // R7
  drain_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 0) |-> (rptr == '0) && (wptr == '0));
  // R8
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_READ) && count == 0) |=> $stable(rd_data) && count == 0);
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (count == STAT_LVL) && (flags == 8'd2));
endmodule

// File: rtl/pio_xfer_fifo.sv
module pio_xfer_fifo #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH) + 2,
  localparam int CMD_AW   = $clog2(CMD_DEPTH),
  localparam int CMD_LW   = $clog2(CMD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              capture,
  input  logic [2:0]        phase,
  input  logic              load_status,
  input  logic [7:0]        status_byte,
  input  logic [CMD_AW-1:0] cmd_rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic [CNT_W-1:0]  count,
  output logic              overrun,
  output logic [7:0]        flags,
  output logic [CMD_LW-1:0] cmd_len,
  output logic [7:0]        cmd_rd_data
);
  logic                    store_we, cap_we;
  logic [PTR_W-1:0]        rptr, wptr;
  logic [7:0]              store_rdata;
  logic signed [CNT_W-1:0] count_s;

  pio_xfer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .load(load_status), .capture(capture), .phase(phase),
    .store_rdata(store_rdata), .store_we(store_we), .cap_we(cap_we),
    .rptr(rptr), .wptr(wptr), .count(count_s), .rd_data(rd_data),
    .irq(irq), .overrun(overrun), .flags(flags)
  );

  pio_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(store_we), .waddr(wptr), .wdata(wr_data),
    .ld(load_status), .ld_byte(status_byte), .raddr(rptr),
    .rdata(store_rdata)
  );

  pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_data(wr_data),
    .rd_addr(cmd_rd_addr), .len(cmd_len), .rd_data(cmd_rd_data)
  );

  assign count = count_s;
endmodule

// File: tb/pio_xfer_fifo_tb.sv
module pio_xfer_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {op[1:0] (1=write,2=read), data[7:0], exp_count[5:0], exp_rd[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd1, 8'hA1, 6'd1, 8'h00}, {2'd1, 8'hB2, 6'd2, 8'h00},
    {2'd1, 8'hC3, 6'd3, 8'h00}, {2'd2, 8'h00, 6'd2, 8'hA1},
    {2'd2, 8'h00, 6'd1, 8'hB2}, {2'd1, 8'hD4, 6'd2, 8'h00},
    {2'd2, 8'h00, 6'd1, 8'hC3}, {2'd2, 8'h00, 6'd0, 8'hD4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, capture = 0, load_status = 0;
  logic [7:0] wr_data = 0, status_byte = 0;
  logic [2:0] phase = 3'b010;
  logic [3:0] cmd_rd_addr = 0;
  logic [7:0] rd_data, flags, cmd_rd_data;
  logic irq, overrun;
  logic [5:0] count;
  logic [4:0] cmd_len;
  int checks = 0, fails = 0;
  logic [7:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_xfer_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .capture(capture), .phase(phase), .load_status(load_status),
    .status_byte(status_byte), .cmd_rd_addr(cmd_rd_addr), .rd_data(rd_data),
    .irq(irq), .count(count), .overrun(overrun), .flags(flags),
    .cmd_len(cmd_len), .cmd_rd_data(cmd_rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Strobes are set at a falling edge and cleared at the next one.
  task automatic step(input logic ld, input logic rd, input logic wr, input logic [7:0] d);
    load_status = ld; rd_en = rd; wr_en = wr; wr_data = d; status_byte = d;
    @(negedge clk);
    load_status = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0); chk("R1 rd_data", rd_data, 0);
    chk("R1 irq", irq, 0); chk("R1 overrun", overrun, 0);
    chk("R1 flags", flags, 0); chk("R1 cmd_len", cmd_len, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R5 table walk, data-in phase
    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, VEC[i][23:22] == 2'd2, VEC[i][23:22] == 2'd1, VEC[i][21:14]);
      chk("R2 count", count, VEC[i][13:8]);
      if (VEC[i][23:22] == 2'd2) begin
        chk("R2 order rd_data", rd_data, VEC[i][7:0]);
        chk("R5 irq pulse", irq, 1);
      end else chk("R5 no irq on write", irq, 0);
    end
    @(negedge clk);
    chk("R5 irq single cycle", irq, 0);

    // R8 zero-count read
    held = rd_data;
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 rd_data held", rd_data, held);
    chk("R8 count", count, 0); chk("R8 irq", irq, 0);

    // R3 overrun at 15
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b1, 8'h10 + 8'(i));
    chk("R3 count full", count, 15); chk("R3 no overrun yet", overrun, 0);
    step(1'b0, 1'b0, 1'b1, 8'hEE);
    chk("R3 count held", count, 15); chk("R3 overrun set", overrun, 1);
    for (int i = 0; i < 15; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R3 drain data", rd_data, 8'h10 + i);
    end
    chk("R3 empty", count, 0);

    // R6 / R7 data-out read, then drain and pointer snap
    step(1'b0, 1'b0, 1'b1, 8'h41);
    step(1'b0, 1'b0, 1'b1, 8'h42);
    phase = 3'b001;
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 data-out zero", rd_data, 0); chk("R6 count", count, 1);
    chk("R6 irq", irq, 1);
    phase = 3'b010;
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 pointer not advanced", rd_data, 8'h41);
    step(1'b0, 1'b0, 1'b1, 8'h77);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R7 snap to index 0", rd_data, 8'h77);

    // R9 status load
    step(1'b1, 1'b0, 1'b0, 8'h5A);
    chk("R9 count", count, 2); chk("R9 flags", flags, 2);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R9 status first", rd_data, 8'h5A);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R9 message zero", rd_data, 8'h00); chk("R9 drained", count, 0);

    // R10 priority
    step(1'b1, 1'b0, 1'b1, 8'h33);
    chk("R10 load beats write", count, 2);
    step(1'b0, 1'b1, 1'b1, 8'h99);
    chk("R10 read beats write count", count, 1);
    chk("R10 read beats write data", rd_data, 8'h33);
    step(1'b0, 1'b1, 1'b0, 8'h00);

    // R4 command capture
    capture = 1'b1;
    for (int i = 0; i < 18; i++) step(1'b0, 1'b0, 1'b1, 8'hC0 + 8'(i));
    capture = 1'b0;
    chk("R4 fifo count unchanged", count, 0);
    chk("R4 cmd_len capped", cmd_len, 16);
    cmd_rd_addr = 4'd0; #1;
    chk("R4 cmd byte 0", cmd_rd_data, 8'hC0);
    cmd_rd_addr = 4'd15; #1;
    chk("R4 cmd byte 15", cmd_rd_data, 8'hCF);

    finish_run();
  end
endmodule